// File: doc/BRIEF.md
# Two-Wire Serial Memory Command Engine

This block is the byte-level slave side of a two-wire serial memory with a 16-bit address space. A separate bit-level front end samples the bus. It hands this block single-cycle event pulses: a start condition, a stop condition, a received byte, or the master's acknowledge or not-acknowledge after a byte the slave sent. The engine answers each received byte with an acknowledge decision. It supplies read data bytes to the front end for shifting out.

Four operations are supported: single-byte write, page write, read at a loaded address, and read at the current address. Writes are collected in a page latch. After the closing stop, a self-timed write cycle copies the latch into a small register array that stands in for the storage cells. While that cycle runs, the engine ignores its own select code. A master can poll with repeated select bytes until it gets an acknowledge. An internal address counter carries the position from one operation to the next.

Top module: `ee_slave_engine`

## Requirements
- R1: A select byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal `strap_ce`. Bit 0 gives the direction: 0 for write, 1 for read. A select that does not match gets `ack_ok`=0, and every later byte up to the next start gets no reply at all.
- R2: A write frame has four parts in order: a write select, the address high byte, the address low byte, and one data byte. When write-control is low, each of these bytes is acknowledged. After the stop and the write cycle, a read at that address returns the data byte.
- R3: A page write can carry several data bytes. Address bits 5:0 advance after each byte and wrap inside the 64-byte page, so bytes past the page end land at the start of the same page. Neighbouring pages are untouched.
- R4: While `wr_lock` is high, the select and address bytes are still acknowledged, but data bytes get `ack_ok`=0. The array keeps its contents, and no write cycle starts, so the next select is acknowledged at once.
- R5: A write frame that latched at least one byte starts a write cycle of `WR_CYCLES` clocks at its stop. During that cycle every select byte gets `ack_ok`=0. Once the cycle ends, selects are acknowledged again.
- R6: A random read is a write select and two address bytes, then a repeated start with no stop, then a read select. The read select is acknowledged, and the byte at the loaded address is presented.
- R7: A read select sent straight after a start presents the byte at the internal counter. The counter goes up by one after every byte presented. Each master acknowledge presents the next byte. A master not-acknowledge followed by a stop ends the read.
- R8: A stop that arrives before the address low byte ends the frame. No write takes place and the address counter keeps its value.
- R9: Reads give the same results whether `wr_lock` is high or low.
- R10: `ack_vld` pulses in the clock cycle after a byte received in the select, address or data phase. `tx_vld` pulses in the cycle after an acknowledged read select or a master acknowledge. No other events produce a reply, and both pulses are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated-start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| bus_byte_vld | input | 1 | Received-byte event pulse |
| bus_byte | input | 8 | Received byte, valid with `bus_byte_vld` |
| bus_mack | input | 1 | Master acknowledged the last byte sent |
| bus_mnack | input | 1 | Master did not acknowledge the last byte sent |
| strap_ce | input | 3 | Chip-enable strap compared with select bits 3:1 |
| wr_lock | input | 1 | Write-control; high blocks writes |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = acknowledge, 0 = withhold |
| tx_vld | output | 1 | Read byte ready for the front end |
| tx_byte | output | 8 | Read byte, valid with `tx_vld` |

## Verification
The assertions assume a well-behaved front end. It raises at most one event pulse per cycle and delivers bytes only after a start. It reports master acknowledge or not-acknowledge only after the engine has presented a read byte. The bench drives each event as a one-cycle pulse with an idle cycle after it. It issues master responses only inside read phases, and it waits longer than the write cycle before it expects a select to be acknowledged again.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam int EE_ADDR_W = 16;
    localparam logic [3:0] EE_SEL_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEL,
        S_AHI,
        S_ALO,
        S_WDAT,
        S_RDAT,
        S_HOLD
    } frame_st_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic byte_v;
        logic mack;
        logic mnack;
    } bus_ev_t;

    function automatic logic sel_hit(input logic [7:0] b, input logic [2:0] ce);
        return (b[7:4] == EE_SEL_TYPE) && (b[3:1] == ce);
    endfunction

endpackage

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
    parameter int WR_CYCLES = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (go && cnt_q == '0) begin
            cnt_q <= CW'(WR_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    // a new cycle is only requested when none is running
    p_go_when_idle_r5: assert property (@(posedge clk) disable iff (rst) go |-> !busy);

endmodule

// File: rtl/ee_page_latch.sv
module ee_page_latch #(
    parameter int MEM_AW     = 8,
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int BASE_W    = MEM_AW - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         commit,
    input  logic                         we,
    input  logic [OFF_W-1:0]             off,
    input  logic [7:0]                   data,
    input  logic                         base_ld,
    input  logic [BASE_W-1:0]            base_in,
    output logic [PAGE_BYTES-1:0][7:0]   buf_q,
    output logic [PAGE_BYTES-1:0]        mask_q,
    output logic [BASE_W-1:0]            base_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            mask_q <= '0;
            base_q <= '0;
        end else begin
            if (clear || commit) begin
                mask_q <= '0;
            end else if (we) begin
                buf_q[off]  <= data;
                mask_q[off] <= 1'b1;
            end
            if (base_ld) begin
                base_q <= base_in;
            end
        end
    end

    // the timed write only fires when the latch holds data
    p_commit_nonempty_r2: assert property (@(posedge clk) disable iff (rst) commit |-> (mask_q != '0));

endmodule

// File: rtl/ee_cell_array.sv
module ee_cell_array #(
    parameter int MEM_AW     = 8,
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int BASE_W    = MEM_AW - OFF_W,
    localparam int DEPTH     = 1 << MEM_AW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit,
    input  logic [BASE_W-1:0]          base,
    input  logic [PAGE_BYTES-1:0][7:0] page_buf,
    input  logic [PAGE_BYTES-1:0]      page_mask,
    input  logic [MEM_AW-1:0]          rd_addr,
    output logic [7:0]                 rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_mask[i]) begin
                    mem[{base, OFF_W'(i)}] <= page_buf[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ee_frame_ctrl.sv
module ee_frame_ctrl
    import ee_pkg::*;
#(
    parameter int MEM_AW     = 8,
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int BASE_W    = MEM_AW - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [7:0]        ev_data,
    input  logic [2:0]        strap_ce,
    input  logic              wr_lock,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              tx_vld,
    output logic [7:0]        tx_byte,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              lat_we,
    output logic [OFF_W-1:0]  lat_off,
    output logic [7:0]        lat_data,
    output logic              lat_base_ld,
    output logic [BASE_W-1:0] lat_base,
    output logic              wr_go
);
    frame_st_t            st_q;
    logic [EE_ADDR_W-1:0] addr_q;
    logic [7:0]           hi_q;
    logic                 have_data_q;
    logic [EE_ADDR_W-1:0] ld_addr;
    logic                 byte_only;

    assign ld_addr     = {hi_q, ev_data};
    assign byte_only   = ev.byte_v && !ev.start && !ev.stop;
    assign mem_addr    = addr_q[MEM_AW-1:0];
    assign lat_we      = byte_only && (st_q == S_WDAT) && !wr_lock;
    assign lat_off     = addr_q[OFF_W-1:0];
    assign lat_data    = ev_data;
    assign lat_base_ld = byte_only && (st_q == S_ALO);
    assign lat_base    = ld_addr[MEM_AW-1:OFF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            addr_q      <= '0;
            hi_q        <= '0;
            have_data_q <= 1'b0;
            ack_vld     <= 1'b0;
            ack_ok      <= 1'b0;
            tx_vld      <= 1'b0;
            tx_byte     <= '0;
            wr_go       <= 1'b0;
        end else begin
            ack_vld <= 1'b0;
            ack_ok  <= 1'b0;
            tx_vld  <= 1'b0;
            wr_go   <= 1'b0;
            if (ev.stop) begin
                if (st_q == S_WDAT && have_data_q) begin
                    wr_go <= 1'b1;
                end
                st_q        <= S_IDLE;
                have_data_q <= 1'b0;
            end else if (ev.start) begin
                st_q        <= S_SEL;
                have_data_q <= 1'b0;
            end else if (ev.byte_v) begin
                unique case (st_q)
                    S_SEL: begin
                        ack_vld <= 1'b1;
                        if (sel_hit(ev_data, strap_ce) && !busy) begin
                            ack_ok <= 1'b1;
                            if (ev_data[0]) begin
                                tx_vld  <= 1'b1;
                                tx_byte <= rd_data;
                                addr_q  <= addr_q + 1'b1;
                                st_q    <= S_RDAT;
                            end else begin
                                st_q <= S_AHI;
                            end
                        end else begin
                            st_q <= S_HOLD;
                        end
                    end
                    S_AHI: begin
                        ack_vld <= 1'b1;
                        ack_ok  <= 1'b1;
                        hi_q    <= ev_data;
                        st_q    <= S_ALO;
                    end
                    S_ALO: begin
                        ack_vld <= 1'b1;
                        ack_ok  <= 1'b1;
                        addr_q  <= ld_addr;
                        st_q    <= S_WDAT;
                    end
                    S_WDAT: begin
                        ack_vld <= 1'b1;
                        if (!wr_lock) begin
                            ack_ok      <= 1'b1;
                            have_data_q <= 1'b1;
                            addr_q      <= {addr_q[EE_ADDR_W-1:OFF_W],
                                            addr_q[OFF_W-1:0] + OFF_W'(1)};
                        end
                    end
                    default: ;
                endcase
            end else if (ev.mack && st_q == S_RDAT) begin
                tx_vld  <= 1'b1;
                tx_byte <= rd_data;
                addr_q  <= addr_q + 1'b1;
            end else if (ev.mnack && st_q == S_RDAT) begin
                st_q <= S_HOLD;
            end
        end
    end

    // input contract: one bus event per cycle at most
    p_one_event_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.start, ev.stop, ev.byte_v, ev.mack, ev.mnack}));
    // a reply decision always follows a received byte by one cycle
    p_ack_after_byte_r10: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> $past(ev.byte_v));
    // select seen while the timed write runs is never acknowledged
    p_busy_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && $past(st_q == S_SEL) && $past(busy)) |-> !ack_ok);
    // data bytes are refused while writes are locked
    p_lock_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && $past(st_q == S_WDAT) && $past(wr_lock)) |-> !ack_ok);

endmodule

// File: rtl/ee_slave_engine.sv
module ee_slave_engine
    import ee_pkg::*;
#(
    parameter int MEM_AW     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int WR_CYCLES  = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       bus_byte_vld,
    input  logic [7:0] bus_byte,
    input  logic       bus_mack,
    input  logic       bus_mnack,
    input  logic [2:0] strap_ce,
    input  logic       wr_lock,
    output logic       ack_vld,
    output logic       ack_ok,
    output logic       tx_vld,
    output logic [7:0] tx_byte
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = MEM_AW - OFF_W;

    bus_ev_t                     ev;
    logic                        busy, done, wr_go;
    logic [MEM_AW-1:0]           mem_addr;
    logic [7:0]                  rd_data;
    logic                        lat_we, lat_base_ld, lat_clear;
    logic [OFF_W-1:0]            lat_off;
    logic [7:0]                  lat_data;
    logic [BASE_W-1:0]           lat_base, base_q;
    logic [PAGE_BYTES-1:0][7:0]  page_buf;
    logic [PAGE_BYTES-1:0]       page_mask;

    assign ev        = '{start: bus_start, stop: bus_stop, byte_v: bus_byte_vld,
                         mack: bus_mack, mnack: bus_mnack};
    assign lat_clear = bus_start && !busy;

    ee_frame_ctrl #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .ev(ev), .ev_data(bus_byte), .strap_ce(strap_ce),
        .wr_lock(wr_lock), .busy(busy), .rd_data(rd_data),
        .ack_vld(ack_vld), .ack_ok(ack_ok), .tx_vld(tx_vld), .tx_byte(tx_byte),
        .mem_addr(mem_addr), .lat_we(lat_we), .lat_off(lat_off), .lat_data(lat_data),
        .lat_base_ld(lat_base_ld), .lat_base(lat_base), .wr_go(wr_go)
    );

    ee_page_latch #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES)) u_latch (
        .clk(clk), .rst(rst), .clear(lat_clear), .commit(done), .we(lat_we),
        .off(lat_off), .data(lat_data), .base_ld(lat_base_ld), .base_in(lat_base),
        .buf_q(page_buf), .mask_q(page_mask), .base_q(base_q)
    );

    ee_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(wr_go), .busy(busy), .done(done)
    );

    ee_cell_array #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst(rst), .commit(done), .base(base_q), .page_buf(page_buf),
        .page_mask(page_mask), .rd_addr(mem_addr), .rd_data(rd_data)
    );

    // no read byte is ever handed out while the cells are being written
    p_no_read_in_write_r6: assert property (@(posedge clk) disable iff (rst) tx_vld |-> !busy);

endmodule

// File: tb/sim_ee_slave_engine.sv
module sim_ee_slave_engine;
    localparam int         WR    = 300;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = 8'hAA;
    localparam logic [7:0] SEL_R = 8'hAB;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_start = 0, bus_stop = 0, bus_byte_vld = 0, bus_mack = 0, bus_mnack = 0;
    logic [7:0] bus_byte = '0;
    logic wr_lock = 1'b0;
    logic ack_vld, ack_ok, tx_vld;
    logic [7:0] tx_byte;

    always #4 clk = ~clk;

    ee_slave_engine #(.WR_CYCLES(WR)) u0 (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte), .bus_mack(bus_mack),
        .bus_mnack(bus_mnack), .strap_ce(STRAP), .wr_lock(wr_lock),
        .ack_vld(ack_vld), .ack_ok(ack_ok), .tx_vld(tx_vld), .tx_byte(tx_byte)
    );

    int cyc = 0, n_chk = 0, n_fail = 0;
    bit fin = 0;
    logic [7:0]  ack_v[$];  int ack_due[$];  string ack_tag[$];
    logic [7:0]  dat_v[$];  int dat_due[$];  string dat_tag[$];
    logic [7:0]  ref_mem [256];
    logic [15:0] ref_cnt = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected replies and compares value and cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_vld) begin
                if (ack_v.size() == 0) chk(0, "R10", "unexpected ack", ack_ok, 0);
                else begin
                    logic [7:0] e; int d; string t;
                    e = ack_v.pop_front(); d = ack_due.pop_front(); t = ack_tag.pop_front();
                    chk(ack_ok == e[0], t, "ack_ok", ack_ok, e[0]);
                    chk(cyc == d, "R10", "ack cycle", cyc, d);
                end
            end
            if (tx_vld) begin
                if (dat_v.size() == 0) chk(0, "R10", "unexpected tx", tx_byte, 0);
                else begin
                    logic [7:0] e; int d; string t;
                    e = dat_v.pop_front(); d = dat_due.pop_front(); t = dat_tag.pop_front();
                    chk(tx_byte == e, t, "tx_byte", tx_byte, e);
                    chk(cyc == d, "R10", "tx cycle", cyc, d);
                end
            end
        end
    end

    task automatic ev_start();
        @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
    endtask
    task automatic ev_stop();
        @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    endtask
    // expk: 0 no reply, 1 acknowledge, 2 withheld
    task automatic put(input logic [7:0] b, input int expk, input string tag);
        @(negedge clk);
        if (expk != 0) begin
            ack_v.push_back({7'd0, expk == 1}); ack_due.push_back(cyc + 1); ack_tag.push_back(tag);
        end
        bus_byte = b; bus_byte_vld = 1;
        @(negedge clk); bus_byte_vld = 0;
    endtask
    task automatic push_dat(input string tag);
        dat_v.push_back(ref_mem[ref_cnt[7:0]]); dat_due.push_back(cyc + 1); dat_tag.push_back(tag);
        ref_cnt = ref_cnt + 16'd1;
    endtask
    task automatic rd_sel(input string tag);
        @(negedge clk);
        ack_v.push_back(8'd1); ack_due.push_back(cyc + 1); ack_tag.push_back(tag);
        push_dat(tag);
        bus_byte = SEL_R; bus_byte_vld = 1;
        @(negedge clk); bus_byte_vld = 0;
    endtask
    task automatic m_ack(input string tag);
        @(negedge clk); push_dat(tag); bus_mack = 1; @(negedge clk); bus_mack = 0;
    endtask
    task automatic m_nack();
        @(negedge clk); bus_mnack = 1; @(negedge clk); bus_mnack = 0;
    endtask
    task automatic load_addr(input logic [15:0] a, input string tag);
        ev_start();
        put(SEL_W, 1, tag); put(a[15:8], 1, tag); put(a[7:0], 1, tag);
        ref_cnt = a;
    endtask
    task automatic wr_data(input logic [7:0] d, input string tag);
        put(d, wr_lock ? 2 : 1, tag);
        if (!wr_lock) begin
            ref_mem[ref_cnt[7:0]] = d;
            ref_cnt = {ref_cnt[15:6], ref_cnt[5:0] + 6'd1};
        end
    endtask
    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        chk(ack_v.size() == 0 && dat_v.size() == 0, tag, "pending replies",
            ack_v.size() + dat_v.size(), 0);
    endtask
    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
            report();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!ack_vld && !tx_vld, "R10", "reset outputs", {ack_vld, tx_vld}, 0);

        // R2 byte write, then R5 polling during the write cycle
        load_addr(16'h0012, "R2");
        wr_data(8'h5C, "R2");
        ev_stop();
        ev_start(); put(SEL_W, 2, "R5"); ev_stop();
        repeat (200) @(negedge clk);
        ev_start(); put(SEL_W, 2, "R5"); ev_stop();
        repeat (120) @(negedge clk);
        // R6 random read through dummy write after the cycle ended
        load_addr(16'h0012, "R5");
        ev_start(); rd_sel("R6"); m_nack(); ev_stop();
        drain("R6");

        // R3 page write wrapping at the page end
        load_addr(16'h007E, "R3");
        wr_data(8'h11, "R3"); wr_data(8'h22, "R3");
        wr_data(8'h33, "R3"); wr_data(8'h44, "R3");
        ev_stop();
        repeat (WR + 20) @(negedge clk);
        load_addr(16'h007E, "R3");
        ev_start(); rd_sel("R3"); m_ack("R3"); m_ack("R3"); m_nack(); ev_stop();
        load_addr(16'h0040, "R3");
        ev_start(); rd_sel("R3"); m_nack(); ev_stop();
        // R7 current address read continues at the counter
        ev_start(); rd_sel("R7"); m_nack(); ev_stop();
        drain("R7");

        // R4 locked write and R9 read under lock
        wr_lock = 1;
        load_addr(16'h0012, "R4");
        wr_data(8'h99, "R4");
        ev_stop();
        load_addr(16'h0012, "R4");
        ev_start(); rd_sel("R9"); m_nack(); ev_stop();
        wr_lock = 0;
        drain("R4");

        // R1 mismatched selects
        ev_start(); put(8'hA2, 2, "R1"); put(8'h00, 0, "R1"); ev_stop();
        ev_start(); put(8'h5A, 2, "R1"); ev_stop();
        ev_start(); rd_sel("R1"); m_nack(); ev_stop();
        drain("R1");

        // R8 stop inside the address phase
        load_addr(16'h007E, "R8");
        ev_start(); rd_sel("R8"); m_nack(); ev_stop();
        ev_start(); put(SEL_W, 1, "R8"); put(8'h01, 1, "R8"); ev_stop();
        ev_start(); rd_sel("R8"); m_nack(); ev_stop();
        ev_start(); put(SEL_W, 1, "R8"); ev_stop();
        ev_start(); rd_sel("R8"); m_nack(); ev_stop();
        drain("R8");

        fin = 1;
        report();
        $finish;
    end
endmodule